// File: doc/BRIEF.md
# Cache Maintenance Command Unit

This unit holds five address registers through which software posts maintenance commands for a data cache. The five commands are prefetch, flush, invalidate, write-back and lock. Software writes an address into one register, and that write posts the command. Each register has an idle value. Any other value means the command is pending. The unit picks one pending command per cycle and runs it against the cache. Once the cache takes the operation, the unit puts the register back to its idle value.

A prefetch becomes a word-read request to the cache and waits for an acknowledge. A flush and an invalidate both run an invalidate, which the unit performs itself on the cache tag array:

- When the cache is present and enabled, it compares the stored tags of the addressed set and clears the way that matches. That way's tag becomes invalid and its age returns to zero.
- When the cache is present but disabled, it clears every way of the addressed set.
- When the cache is absent, the command is dropped and the register still clears.

Write-back and lock commands are taken and cleared with no cache action.

Top module: `cmaint_unit`

## Requirements
- R1: After reset, the flush register reads all ones. The prefetch, invalidate, write-back and lock registers read zero.
- R2: A nonzero prefetch register drives `pf_req` with `pf_addr` equal to the register. The register reads zero starting in the cycle after one in which `pf_ack` is high with `pf_req`.
- R3: A flush register that is not all ones starts an invalidate of its address. Once the invalidate is taken, the register reads all ones again.
- R4: A nonzero invalidate register starts an invalidate of its address. Once the invalidate is taken, the register reads zero.
- R5: A nonzero write-back or lock register is cleared to zero in the cycle after it is selected. Neither raises `pf_req` nor `tag_req`.
- R6: With the cache present and enabled, an invalidate clears exactly the valid ways whose stored tag equals the address tag. It raises `tag_wr_en` with those ways in `tag_wr_mask`. If no way matches, it writes nothing and the register still clears.
- R7: With the cache present and disabled, an invalidate writes `tag_wr_mask` all ones for the addressed set.
- R8: With the cache absent, an invalidate raises neither `tag_req` nor `tag_wr_en`, and its register clears in the cycle after it is selected.
- R9: When several commands are pending, only one is serviced per cycle, in the order prefetch, flush, invalidate, write-back, lock. `pf_req` and `tag_req` are never high together.
- R10: A register clears only after its operation is taken: `pf_ack` for a prefetch, `tag_gnt` for an invalidate while the cache is present. A write to a register that is pending raises `wr_stall` and does not change the register.
- R11: Register selects are 0 prefetch, 1 flush, 2 invalidate, 3 write-back, 4 lock. Selects 5 to 7 read zero, and writes to them are ignored.
- R12: The set index is `addr[OFFW+:IDXW]` and the tag is `addr[AW-1:OFFW+IDXW]`. Bit i of the tag vectors and of `tag_wr_mask` is way i. A tag write clears validity and age of the masked ways.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cache_present | input | 1 | A data cache is fitted |
| cache_enable | input | 1 | The data cache is enabled |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for write |
| wr_data | input | AW | Address written |
| wr_stall | output | 1 | Write is held off because the register is pending |
| rd_sel | input | 3 | Register select for read |
| rd_data | output | AW | Register contents |
| pf_req | output | 1 | Prefetch word-read request |
| pf_addr | output | AW | Prefetch address |
| pf_ack | input | 1 | Cache takes the prefetch |
| tag_req | output | 1 | Tag array access request for an invalidate |
| tag_gnt | input | 1 | Tag array granted this cycle |
| tag_set | output | IDXW | Set being looked up |
| tag_valid_i | input | NWAYS | Valid bit of each way in the set |
| tag_i | input | NWAYS*TAGW | Stored tag of each way |
| tag_wr_en | output | 1 | Tag write strobe |
| tag_wr_mask | output | NWAYS | Ways to invalidate and whose age is zeroed |

## Verification
Request, stall and tag-write outputs are combinational from the register state and the inputs of the same cycle. They are due in the cycle in which the command is selected. A register's new value appears on `rd_data` one clock after its write or its acceptance. The bench applies inputs at the falling edge and compares every output 2 ns later against a behavioural model. It advances the model at the rising edge, so each check samples the cycle in which its result is due.

// File: rtl/cmaint_unit.sv
`timescale 1ns/1ps
module cmaint_unit #(
  parameter int AW     = 32,
  parameter int NSETS  = 4,
  parameter int NWAYS  = 2,
  parameter int OFFW   = 4,
  localparam int IDXW  = $clog2(NSETS),
  localparam int TAGW  = AW - OFFW - IDXW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cache_present,
  input  logic                  cache_enable,
  input  logic                  wr_en,
  input  logic [2:0]            wr_sel,
  input  logic [AW-1:0]         wr_data,
  output logic                  wr_stall,
  input  logic [2:0]            rd_sel,
  output logic [AW-1:0]         rd_data,
  output logic                  pf_req,
  output logic [AW-1:0]         pf_addr,
  input  logic                  pf_ack,
  output logic                  tag_req,
  input  logic                  tag_gnt,
  output logic [IDXW-1:0]       tag_set,
  input  logic [NWAYS-1:0]      tag_valid_i,
  input  logic [NWAYS*TAGW-1:0] tag_i,
  output logic                  tag_wr_en,
  output logic [NWAYS-1:0]      tag_wr_mask
);
  localparam int NCMD = 5;

  logic [AW-1:0]    cmd_q [NCMD];
  logic [7:0]       pend;
  logic [NCMD-1:0]  grant;
  logic             inval, done;
  logic [TAGW-1:0]  op_tag;
  logic [NWAYS-1:0] hit;

  assign pend[0]   = |cmd_q[0];
  assign pend[1]   = ~&cmd_q[1];
  assign pend[2]   = |cmd_q[2];
  assign pend[3]   = |cmd_q[3];
  assign pend[4]   = |cmd_q[4];
  assign pend[7:5] = '0;

  assign grant = pend[NCMD-1:0] & (~pend[NCMD-1:0] + 1'b1);
  assign inval = grant[1] | grant[2];

  assign pf_req  = grant[0];
  assign pf_addr = cmd_q[0];

  assign tag_req = inval & cache_present;
  assign tag_set = grant[1] ? cmd_q[1][OFFW +: IDXW] : cmd_q[2][OFFW +: IDXW];
  assign op_tag  = grant[1] ? cmd_q[1][AW-1 -: TAGW] : cmd_q[2][AW-1 -: TAGW];

  for (genvar w = 0; w < NWAYS; w++) begin : g_cmp
    assign hit[w] = tag_valid_i[w] && (tag_i[w*TAGW +: TAGW] == op_tag);
  end

  assign tag_wr_mask = cache_enable ? hit : '1;
  assign tag_wr_en   = tag_req & tag_gnt & (|tag_wr_mask);

  assign done = (grant[0] & pf_ack) | (inval & (~cache_present | tag_gnt))
              | grant[3] | grant[4];

  assign wr_stall = wr_en & pend[wr_sel];

  for (genvar i = 0; i < NCMD; i++) begin : g_reg
    localparam logic [AW-1:0] IDLE = (i == 1) ? '1 : '0;
    always_ff @(posedge clk) begin
      if (!rst_n)
        cmd_q[i] <= IDLE;
      else if (done && grant[i])
        cmd_q[i] <= IDLE;
      else if (wr_en && wr_sel == 3'(i) && !pend[i])
        cmd_q[i] <= wr_data;
    end
  end

  always_comb begin
    case (rd_sel)
      3'd0: rd_data = cmd_q[0];
      3'd1: rd_data = cmd_q[1];
      3'd2: rd_data = cmd_q[2];
      3'd3: rd_data = cmd_q[3];
      3'd4: rd_data = cmd_q[4];
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/cmaint_unit_chk.sv
`timescale 1ns/1ps
module cmaint_unit_chk #(
  parameter int AW    = 32,
  parameter int NWAYS = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cache_present,
  input logic             cache_enable,
  input logic             pf_req,
  input logic [AW-1:0]    pf_addr,
  input logic             pf_ack,
  input logic             tag_req,
  input logic             tag_gnt,
  input logic             tag_wr_en,
  input logic [NWAYS-1:0] tag_wr_mask
);
  AST_SINGLE_OP: assert property (@(posedge clk) disable iff (!rst_n)
    !(pf_req && tag_req)); // R9
  AST_PF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pf_req && !pf_ack |=> pf_req && $stable(pf_addr)); // R10
  AST_WR_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
    tag_wr_en |-> tag_req && tag_gnt); // R6
  AST_DISABLED_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    tag_wr_en && !cache_enable |-> &tag_wr_mask); // R7
  AST_ABSENT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cache_present |-> !tag_req && !tag_wr_en); // R8
endmodule

bind cmaint_unit cmaint_unit_chk #(.AW(AW), .NWAYS(NWAYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cache_present(cache_present),
  .cache_enable(cache_enable), .pf_req(pf_req), .pf_addr(pf_addr),
  .pf_ack(pf_ack), .tag_req(tag_req), .tag_gnt(tag_gnt),
  .tag_wr_en(tag_wr_en), .tag_wr_mask(tag_wr_mask)
);

// File: tb/cmaint_unit_test.sv
`timescale 1ns/1ps
module cmaint_unit_test;
  localparam int AW = 32, NSETS = 4, NWAYS = 2, OFFW = 4;
  localparam int IDXW = 2, TAGW = AW - OFFW - IDXW;

  logic clk = 0, rst_n = 0;
  logic cache_present = 1, cache_enable = 1;
  logic wr_en = 0; logic [2:0] wr_sel = 0; logic [AW-1:0] wr_data = 0;
  logic [2:0] rd_sel = 0;
  logic pf_ack = 0, tag_gnt = 0;
  logic wr_stall, pf_req, tag_req, tag_wr_en;
  logic [AW-1:0] rd_data, pf_addr;
  logic [IDXW-1:0] tag_set;
  logic [NWAYS-1:0] tag_valid_i, tag_wr_mask;
  logic [NWAYS*TAGW-1:0] tag_i;

  logic mv [NSETS][NWAYS];
  logic [TAGW-1:0] mt [NSETS][NWAYS];
  logic [AW-1:0] m [5];
  int vectors = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cmaint_unit uut (.*);

  always_comb
    for (int w = 0; w < NWAYS; w++) begin
      tag_valid_i[w] = mv[tag_set][w];
      tag_i[w*TAGW +: TAGW] = mt[tag_set][w];
    end

  function automatic bit pending(int i);
    return (i == 1) ? (m[1] != '1) : (i < 5 && m[i] != 0);
  endfunction

  task automatic chk(string rq, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic cyc(string rq);
    int sel = -1;
    bit inval, e_treq, e_twe, e_stall, acc;
    int set;
    logic [TAGW-1:0] tg;
    logic [NWAYS-1:0] mask;
    #2;
    for (int i = 0; i < 5; i++) if (sel < 0 && pending(i)) sel = i;
    inval = (sel == 1 || sel == 2);
    e_treq = inval && cache_present;
    set = 0; tg = 0; mask = 0;
    if (inval) begin
      set = int'((m[sel] >> OFFW) % NSETS);
      tg = TAGW'(m[sel] >> (OFFW + IDXW));
      for (int w = 0; w < NWAYS; w++)
        mask[w] = cache_enable ? (mv[set][w] && mt[set][w] == tg) : 1'b1;
    end
    e_twe = e_treq && tag_gnt && (mask != 0);
    e_stall = wr_en && wr_sel < 5 && pending(int'(wr_sel));
    acc = (sel == 0 && pf_ack) || (inval && (!cache_present || tag_gnt)) || sel >= 3;
    chk(rq, "pf_req", AW'(pf_req), AW'(sel == 0));
    if (sel == 0) chk(rq, "pf_addr", pf_addr, m[0]);
    chk(rq, "tag_req", AW'(tag_req), AW'(e_treq));
    if (e_treq) chk(rq, "tag_set", AW'(tag_set), AW'(set));
    chk(rq, "tag_wr_en", AW'(tag_wr_en), AW'(e_twe));
    if (e_twe) chk(rq, "tag_wr_mask", AW'(tag_wr_mask), AW'(mask));
    chk(rq, "wr_stall", AW'(wr_stall), AW'(e_stall));
    chk(rq, "rd_data", rd_data, rd_sel < 5 ? m[rd_sel] : '0);
    @(posedge clk);
    if (acc) m[sel] = (sel == 1) ? '1 : '0;
    if (wr_en && wr_sel < 5 && !e_stall) m[wr_sel] = wr_data;
    if (e_twe) for (int w = 0; w < NWAYS; w++) if (mask[w]) mv[set][w] = 0;
    @(negedge clk);
  endtask

  task automatic wr(int sel, logic [AW-1:0] d, string rq);
    wr_en = 1; wr_sel = 3'(sel); wr_data = d; rd_sel = 3'(sel);
    cyc(rq);
    wr_en = 0;
  endtask

  task automatic idle(int n, int rs, string rq);
    rd_sel = 3'(rs);
    for (int k = 0; k < n; k++) cyc(rq);
  endtask

  function automatic logic [AW-1:0] mk(int tg, int set, int off);
    return AW'((tg << (OFFW + IDXW)) | (set << OFFW) | off);
  endfunction

  initial begin
    for (int s = 0; s < NSETS; s++)
      for (int w = 0; w < NWAYS; w++) begin mv[s][w] = 0; mt[s][w] = 0; end
    m[0] = 0; m[1] = '1; m[2] = 0; m[3] = 0; m[4] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 8; i++) begin rd_sel = 3'(i); cyc("R1"); end
    mv[1][0] = 1; mt[1][0] = 7; mv[1][1] = 1; mt[1][1] = 5;
    mv[2][0] = 1; mt[2][0] = 3; mv[2][1] = 1; mt[2][1] = 4;
    tag_gnt = 1;
    wr(2, mk(5, 1, 4), "R4"); idle(2, 2, "R6");
    wr(2, mk(9, 1, 8), "R6"); idle(2, 2, "R6");
    wr(1, mk(7, 1, 0), "R3"); idle(2, 1, "R3");
    wr(1, mk(7, 1, 0), "R12"); idle(1, 1, "R12");
    cache_enable = 0;
    wr(2, mk(1, 2, 0), "R7"); idle(2, 2, "R7");
    cache_enable = 1; cache_present = 0;
    wr(1, mk(1, 3, 0), "R8"); idle(2, 1, "R8");
    cache_present = 1;
    mv[3][1] = 1; mt[3][1] = 2; tag_gnt = 0;
    wr(2, mk(2, 3, 12), "R10"); idle(2, 2, "R10");
    wr(2, 32'h1234, "R10"); tag_gnt = 1; idle(2, 2, "R10");
    wr(0, 32'h0000_0100, "R2"); idle(2, 0, "R2");
    wr(0, 32'h0000_0200, "R10");
    pf_ack = 1; idle(2, 0, "R2"); pf_ack = 0;
    wr(3, 32'hdead_0000, "R5"); idle(1, 3, "R5");
    wr(4, 32'h0000_beef, "R5"); idle(1, 4, "R5");
    tag_gnt = 0;
    wr(4, 32'h44, "R9"); wr(3, 32'h33, "R9"); wr(2, mk(6, 0, 0), "R9");
    wr(1, mk(6, 1, 0), "R9"); wr(0, 32'h80, "R9");
    idle(2, 1, "R9");
    pf_ack = 1; idle(1, 0, "R9"); pf_ack = 0;
    tag_gnt = 1;
    for (int k = 0; k < 6; k++) idle(1, k % 5, "R9");
    wr(6, 32'h55, "R11"); idle(1, 6, "R11");
    wr(7, 32'h77, "R11"); idle(1, 7, "R11");
    for (int i = 0; i < 5; i++) idle(1, i, "R11");
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule